// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address that a synchronous burst memory array sees on each clock. When an address strobe is accepted, it captures an external address. On each later clock it then either moves to the next beat of a four-beat burst or holds the current beat. Only the two least significant address bits take part in the burst. The bits above them stay exactly as they were captured.

A static mode input picks the beat order. In linear order the offset counts upward modulo four. In interleaved order the offset is the start offset XORed with the beat number. There are two strobes. The processor-side strobe is masked whenever the primary active-low chip enable is inactive. The controller-side strobe always loads. A registered chip-select flag records the combined enable state, and it is sampled only on cycles that load an address.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is applied, and after it is released, `word_addr` reads 0 and `chip_sel` reads 0 until the first load.
- R2: When `adsc_n` is low at a clock edge, `addr_in` appears on `word_addr` after that edge, whatever `ce_n` is.
- R3: When `adsp_n` is low and `ce_n` is low, `addr_in` is loaded. When `ce_n` is high, `adsp_n` is ignored: with `adv_n` high the address and `chip_sel` are unchanged, and with `adv_n` low the burst simply advances.
- R4: With `order_il` = 0 (linear), beat k of a burst has low bits (start + k) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_il` = 1 (interleaved), beat k of a burst has low bits start XOR k. For example, start 01 gives 01, 00, 11, 10.
- R6: After the fourth beat, one more advance returns the low bits to the start offset.
- R7: With no strobe accepted and `adv_n` high, `word_addr` holds its value (suspend).
- R8: A load is accepted on any cycle, including mid-burst and when both strobes are low, and it restarts the burst at beat 0 of the new address.
- R9: On a load, `chip_sel` takes the value (`ce_n` low AND `ce2` high AND `ce3_n` low). On cycles without a load, `chip_sel` is unchanged whatever the enables do.
- R10: `word_addr[ADDR_W-1:2]` never changes except on a load. Advances do not carry into these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adsp_n | input | 1 | Processor-side address strobe, active low, masked by `ce_n` |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance enable, active low |
| order_il | input | 1 | Beat order: 0 linear, 1 interleaved |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high, sampled on loads |
| ce3_n | input | 1 | Secondary chip enable, active low, sampled on loads |
| addr_in | input | ADDR_W | External word address |
| word_addr | output | ADDR_W | Registered word address presented to the array |
| chip_sel | output | 1 | Registered chip-selected state captured at the last load |

## Verification
The ordering logic is swept over every start offset in both orders, with five advances per burst. This separates the linear pattern from the interleaved one, and the fifth beat shows that the counter wraps rather than carrying into the upper bits. Suspend runs and reloads in the middle of a burst show that hold and restart differ from advance. The strobe patterns include a masked processor strobe with advance low and with advance high, a controller strobe while the primary enable is inactive, and both strobes at once. Together they tell apart the two strobes' qualification rules. Loads with each enable deasserted in turn, followed by enable toggles that come without a load, show when the select flag is sampled.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned BEAT_W    = $clog2(BURST_LEN);

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } beat_order_e;

  // Offset presented for a given beat, start offset and ordering.
  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input beat_order_e       ord
  );
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/bsg_rst_sync.sv
module bsg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsg_load_reg.sv
module bsg_load_reg #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic                     sel_d,
  input  logic [ADDR_W-1:0]        addr_d,
  output logic [ADDR_W-1:BEAT_W]   upper_q,
  output logic [BEAT_W-1:0]        start_q,
  output logic                     sel_q
);
  logic [ADDR_W-1:BEAT_W] upper_n;
  logic [BEAT_W-1:0]      start_n;
  logic                   sel_n;

  always_comb begin
    upper_n = upper_q;
    start_n = start_q;
    sel_n   = sel_q;
    if (ld_en) begin
      upper_n = addr_d[ADDR_W-1:BEAT_W];
      start_n = addr_d[BEAT_W-1:0];
      sel_n   = sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      sel_q   <= 1'b0;
    end else begin
      upper_q <= upper_n;
      start_q <= start_n;
      sel_q   <= sel_n;
    end
  end
endmodule

// File: rtl/bsg_beat_ctr.sv
module bsg_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);
  logic [BEAT_W-1:0] beat_n;

  always_comb begin
    beat_n = beat_q;
    if (clr)       beat_n = '0;
    else if (step) beat_n = beat_q + 1'b1;  // wraps modulo burst length
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_n;
  end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import bsg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              order_il,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              chip_sel
);
  localparam int unsigned BW = BEAT_W;

  logic                 rst_sync_n;
  logic                 proc_ld;
  logic                 ctl_ld;
  logic                 ld_en;
  logic                 step_en;
  logic                 sel_d;
  logic [ADDR_W-1:BW]   upper_q;
  logic [BW-1:0]        start_q;
  logic [BW-1:0]        beat_q;
  beat_order_e          ord;

  bsg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // The processor strobe wins when unmasked; both strobes capture the
  // same bus, so only the qualification differs.
  always_comb begin
    proc_ld = !adsp_n && !ce_n;
    ctl_ld  = !adsc_n;
    ld_en   = proc_ld || ctl_ld;
    sel_d   = proc_ld ? (ce2 && !ce3_n) : (!ce_n && ce2 && !ce3_n);
    step_en = !ld_en && !adv_n;
    ord     = beat_order_e'(order_il);
  end

  bsg_load_reg #(.ADDR_W(ADDR_W), .BEAT_W(BW)) u_load (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_en   (ld_en),
    .sel_d   (sel_d),
    .addr_d  (addr_in),
    .upper_q (upper_q),
    .start_q (start_q),
    .sel_q   (chip_sel)
  );

  bsg_beat_ctr #(.BEAT_W(BW)) u_beat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (ld_en),
    .step   (step_en),
    .beat_q (beat_q)
  );

  assign word_addr = {upper_q, beat_offset(start_q, beat_q, ord)};
endmodule

// File: rtl/burst_seq_gen_chk.sv
module burst_seq_gen_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              adv_n,
  input logic              order_il,
  input logic              ce_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] word_addr,
  input logic              chip_sel,
  input logic [1:0]        beat_q
);
  logic any_ld;
  assign any_ld = !adsc_n || (!adsp_n && !ce_n);

  // R2
  p_ctl_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !adsc_n |=> word_addr == $past(addr_in));

  // R3
  p_masked_proc_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (adsc_n && ce_n && adv_n) |=> ($stable(beat_q) && $stable(chip_sel)));

  // R6
  p_wrap_step_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!any_ld && !adv_n) |=> beat_q == 2'($past(beat_q) + 2'd1));

  // R7
  p_suspend_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!any_ld && adv_n && $stable(order_il)) |=> $stable(beat_q));

  // R8
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    any_ld |=> beat_q == 2'd0);

  // R9
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_ld |=> $stable(chip_sel));

  // R10
  p_upper_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_ld |=> $stable(word_addr[ADDR_W-1:2]));
endmodule

bind burst_seq_gen burst_seq_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .adsp_n     (adsp_n),
  .adsc_n     (adsc_n),
  .adv_n      (adv_n),
  .order_il   (order_il),
  .ce_n       (ce_n),
  .addr_in    (addr_in),
  .word_addr  (word_addr),
  .chip_sel   (chip_sel),
  .beat_q     (beat_q)
);

// File: tb/burst_seq_gen_tb_top.sv
module burst_seq_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        adsp_n, adsc_n, adv_n, order_il, ce_n, ce2, ce3_n;
  logic [15:0] addr_in;
  logic [15:0] word_addr;
  logic        chip_sel;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 1'b0;

  always #5 clk = ~clk;

  burst_seq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .order_il(order_il), .ce_n(ce_n), .ce2(ce2), .ce3_n(ce3_n),
    .addr_in(addr_in), .word_addr(word_addr), .chip_sel(chip_sel)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive inputs right after a falling edge; sample at the next falling edge.
  task automatic cyc(input logic p, input logic c, input logic a,
                     input logic e, input logic e2, input logic e3,
                     input logic [15:0] ad);
    adsp_n = p; adsc_n = c; adv_n = a; ce_n = e; ce2 = e2; ce3_n = e3;
    addr_in = ad;
    @(negedge clk);
  endtask

  function automatic logic [1:0] exp_lo(input logic ord, input logic [1:0] s,
                                        input int k);
    logic [1:0] kb;
    kb = 2'(k);
    return ord ? (s ^ kb) : 2'(s + kb);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    rst_n = 1'b0; order_il = 1'b0;
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce_n = 0; ce2 = 1; ce3_n = 0; addr_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", word_addr, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 post-reset addr", word_addr, 16'h0000);
    chk("R1 post-reset sel", {15'b0, chip_sel}, 16'h0000);

    // Sweep every start offset in both orders, five advances each.
    for (int ord = 0; ord < 2; ord++) begin
      order_il = ord[0];
      for (int s = 0; s < 4; s++) begin
        a = (16'hA5C0 ^ 16'(ord << 6) ^ 16'(s << 4)) | 16'(s);
        cyc(1, 0, 1, 0, 1, 0, a);
        chk("R2 controller load", word_addr, a);
        for (int k = 1; k <= 5; k++) begin
          cyc(1, 1, 0, 0, 1, 0, 16'h0000);
          chk(k == 4 ? "R6 wrap" : (ord == 1 ? "R5 interleave" : "R4 linear"),
              {14'b0, word_addr[1:0]}, {14'b0, exp_lo(ord[0], a[1:0], k)});
          chk("R10 upper bits", {word_addr[15:2], 2'b0}, {a[15:2], 2'b0});
        end
      end
    end

    // Suspend.
    order_il = 1'b0;
    cyc(1, 0, 1, 0, 1, 0, 16'h4002);
    cyc(1, 1, 0, 0, 1, 0, 16'h0000);
    chk("R4 linear step", word_addr, 16'h4003);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 1, 1, 0, 1, 0, 16'h1111);
      chk("R7 suspend", word_addr, 16'h4003);
    end
    cyc(1, 1, 0, 0, 1, 0, 16'h0000);
    chk("R7 resume", word_addr, 16'h4000);

    // Processor load mid-burst, then step.
    cyc(0, 1, 1, 0, 1, 0, 16'h7771);
    chk("R8 reload mid-burst", word_addr, 16'h7771);
    chk("R3 processor load", {15'b0, chip_sel}, 16'h0001);
    cyc(1, 1, 0, 0, 1, 0, 16'h0000);
    chk("R8 restart beat", word_addr, 16'h7772);

    // Masked processor strobe: hold then advance.
    cyc(0, 1, 1, 1, 1, 0, 16'h0BAD);
    chk("R3 masked hold addr", word_addr, 16'h7772);
    chk("R3 masked hold sel", {15'b0, chip_sel}, 16'h0001);
    cyc(0, 1, 0, 1, 1, 0, 16'h0BAD);
    chk("R3 masked advance", word_addr, 16'h7773);

    // Controller strobe with primary enable inactive.
    cyc(1, 0, 1, 1, 1, 0, 16'h2224);
    chk("R2 load with ce_n high", word_addr, 16'h2224);
    chk("R9 sel on ce_n high", {15'b0, chip_sel}, 16'h0000);

    // Secondary enables.
    cyc(1, 0, 1, 0, 0, 0, 16'h3330);
    chk("R9 sel ce2 low", {15'b0, chip_sel}, 16'h0000);
    cyc(1, 0, 1, 0, 1, 1, 16'h3331);
    chk("R9 sel ce3_n high", {15'b0, chip_sel}, 16'h0000);
    cyc(1, 0, 1, 0, 1, 0, 16'h3332);
    chk("R9 sel all active", {15'b0, chip_sel}, 16'h0001);
    cyc(1, 1, 0, 1, 0, 1, 16'h0000);
    chk("R9 enables ignored without load", {15'b0, chip_sel}, 16'h0001);
    chk("R9 advance during toggle", word_addr, 16'h3333);

    // Both strobes together, interleaved order.
    order_il = 1'b1;
    cyc(0, 0, 1, 0, 1, 0, 16'h5556);
    chk("R8 both strobes load", word_addr, 16'h5556);
    cyc(1, 1, 0, 0, 1, 0, 16'h0000);
    chk("R5 interleave after dual load", word_addr, 16'h5557);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule